// File: doc/BRIEF.md
# Multi-Channel Converter Warm-Up Sequencer

This block sequences power-up for four converter channels that share one control clock. A single configuration register holds a reference select, a shared warm-up code, one analog enable and one digital enable per channel, and a control-clock divide field. The input clock is divided by (divide field + 1) to form a control tick. Each channel divides that tick again by twice its own divider value to form its conversion clock.

Once a channel's analog enable is set and the global enable runs the clocks, the channel counts a power-of-two number of conversion clocks, with a floor of 16. It then raises a sticky ready flag, which software clears by writing 1. The digital path of a channel becomes ready one conversion clock after both its digital enable and a finished warm-up are present. The analog enable gates the digital path completely.

While the global enable is high, the configuration register refuses writes and answers each attempt with a one-cycle error pulse. Counting only advances while the global enable is high.

Top module: `adc_warmup_seq`

## Requirements
- R1: After reset the register reads 0, and all ready outputs and the error output are 0.
- R2: A write while `glb_en`=1 leaves the register unchanged and raises `cfg_werr` for exactly one cycle after the write edge. A write while `glb_en`=0 is stored and gives no error.
- R3: Stored fields are: reference select [30:28], warm-up code [27:24], analog enables [23:20] (bit 20+i for channel i), digital enables [19:16] (bit 16+i), control divide D [13:8]. All other bits read 0, so writing all ones reads back 0x7FFF3F00.
- R4: The warm-up length T in conversion clocks is 16 for codes 0 to 4 and 2^code for codes 5 to 15 (32768 for code 15).
- R5: The conversion clock of channel i lasts 2·M·(D+1) input cycles, where M is the channel's 4-bit divider value (`chan_div[4i+3:4i]`) and a value of 0 counts as 1. With glb_en raised after configuration, `ana_rdy[i]` is first seen high after exactly T·2·M·(D+1) enabled clock edges.
- R6: Clearing a channel's analog enable drops its `ana_rdy` and `dig_rdy` at once and restarts its warm-up from zero.
- R7: `ana_rdy[i]` is sticky. It is cleared by `rdy_clr[i]`=1, it stays 0 afterwards while the channel remains warm, and it sets again only at the end of a new warm-up.
- R8: `dig_rdy[i]` is 1 only when both enables of channel i are set. It first rises one conversion clock (2·M·(D+1) edges) after the warm-up finishes.
- R9: Counting only advances on edges where `glb_en`=1. A pause holds warm-up progress, and the partial control period restarts when counting resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable: runs the clocks and locks the register |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register contents |
| cfg_werr | output | 1 | One-cycle pulse for a refused write |
| chan_div | input | 16 | Per-channel conversion divider, 4 bits per channel |
| rdy_clr | input | 4 | Write-1-to-clear for the ready flags |
| ana_rdy | output | 4 | Sticky warm-up-done flags |
| dig_rdy | output | 4 | Digital-path ready per channel |

## Verification
The timing sweep covers warm-up codes 0 to 7 across three control-divide values. Each run uses four different channel dividers, including a zero. This tells the floor-of-16 codes apart from the power-of-two codes, and it shows whether the 2·M factor, the (D+1) factor and the zero-as-one rule are each applied. One long run at code 15 exercises the widest count. Further patterns cover a pause of the global enable in mid warm-up, write-1-clear followed by further running, removing and restoring the analog enable, mixed enable masks for the gating, and register writes both while locked and while unlocked.

// File: rtl/adc_ws_pkg.sv
package adc_ws_pkg;
    localparam int NCH      = 4;
    localparam int CODE_W   = 4;
    localparam int CDIV_W   = 6;
    localparam int CHDIV_W  = 4;
    localparam int WCNT_W   = (2 ** CODE_W) - 1;
    localparam int FLOOR_EXP = 4;

    localparam int VREF_LSB = 28;
    localparam int CODE_LSB = 24;
    localparam int ANA_LSB  = 20;
    localparam int DIG_LSB  = 16;
    localparam int CDIV_LSB = 8;

    localparam logic [31:0] CFG_MASK =
          (32'h7 << VREF_LSB)
        | (32'((2 ** CODE_W) - 1) << CODE_LSB)
        | (32'((2 ** NCH) - 1) << ANA_LSB)
        | (32'((2 ** NCH) - 1) << DIG_LSB)
        | (32'((2 ** CDIV_W) - 1) << CDIV_LSB);

    // last index of the warm-up count: 2^max(code, floor) - 1
    function automatic logic [WCNT_W-1:0] warm_last_of(input logic [CODE_W-1:0] code);
        logic [WCNT_W:0] span;
        int unsigned     e;
        e    = (int'(code) < FLOOR_EXP) ? FLOOR_EXP : int'(code);
        span = (WCNT_W+1)'(1) << e;
        return WCNT_W'(span - 1'b1);
    endfunction
endpackage

// File: rtl/adc_ws_cfg_reg.sv
module adc_ws_cfg_reg
    import adc_ws_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        glb_en,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        werr
);
    typedef struct packed {
        logic [31:0] word;
        logic        err;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = wr && glb_en;
        if (wr && !glb_en) begin
            st_d.word = wdata & CFG_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.word;
    assign werr  = st_q.err;

    AST_WERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        werr |-> $past(wr && glb_en)); // R2
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(glb_en) |-> $stable(rdata)); // R2
endmodule

// File: rtl/adc_ws_prescale.sv
module adc_ws_prescale #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    assign tick = run && (st_q.cnt == div);

    always_comb begin
        st_d = st_q;
        if (!run)      st_d.cnt = '0;
        else if (tick) st_d.cnt = '0;
        else           st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PRESCALE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0)); // R9
    AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (st_q.cnt <= div)); // R5
endmodule

// File: rtl/adc_ws_chan.sv
module adc_ws_chan
    import adc_ws_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_tick,
    input  logic              ana_en,
    input  logic              dig_en,
    input  logic [DIV_W-1:0]  div,
    input  logic [WCNT_W-1:0] warm_last,
    input  logic              rdy_clr,
    output logic              ana_rdy,
    output logic              dig_rdy
);
    typedef struct packed {
        logic [DIV_W:0]    cdiv;
        logic [WCNT_W-1:0] warm;
        logic              done;
        logic              rdy;
        logic              dok;
    } ch_st_t;

    ch_st_t st_d, st_q;

    logic [DIV_W-1:0] m_eff;
    logic [DIV_W:0]   conv_last;
    logic             conv_tick;

    assign m_eff     = (div == '0) ? DIV_W'(1) : div;
    assign conv_last = {m_eff, 1'b0} - 1'b1;
    assign conv_tick = ana_en && ctl_tick && (st_q.cdiv == conv_last);

    always_comb begin
        st_d = st_q;
        if (!ana_en) begin
            st_d = '0;
        end else begin
            if (ctl_tick) begin
                st_d.cdiv = (st_q.cdiv == conv_last) ? '0 : st_q.cdiv + 1'b1;
            end
            if (rdy_clr) begin
                st_d.rdy = 1'b0;
            end
            if (conv_tick && !st_q.done) begin
                if (st_q.warm >= warm_last) begin
                    st_d.done = 1'b1;
                    st_d.rdy  = 1'b1;
                end else begin
                    st_d.warm = st_q.warm + 1'b1;
                end
            end
            if (!dig_en || !st_q.done) begin
                st_d.dok = 1'b0;
            end else if (conv_tick) begin
                st_d.dok = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ana_rdy = st_q.rdy && ana_en;
    assign dig_rdy = st_q.dok && ana_en && dig_en;

    AST_RDY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rdy |-> st_q.done); // R7
    AST_RDY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rdy) |-> $past(conv_tick)); // R4
    AST_DIG_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dok |-> st_q.done); // R8
endmodule

// File: rtl/adc_warmup_seq.sv
module adc_warmup_seq
    import adc_ws_pkg::*;
#(
    parameter int CH_DIV_W = CHDIV_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    glb_en,
    input  logic                    cfg_wr,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    output logic                    cfg_werr,
    input  logic [NCH*CH_DIV_W-1:0] chan_div,
    input  logic [NCH-1:0]          rdy_clr,
    output logic [NCH-1:0]          ana_rdy,
    output logic [NCH-1:0]          dig_rdy
);
    logic [CODE_W-1:0] code;
    logic [NCH-1:0]    ana_en;
    logic [NCH-1:0]    dig_en;
    logic [CDIV_W-1:0] ctl_div;
    logic [WCNT_W-1:0] warm_last;
    logic              ctl_tick;

    adc_ws_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .glb_en(glb_en),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .werr  (cfg_werr)
    );

    assign code      = cfg_rdata[CODE_LSB +: CODE_W];
    assign ana_en    = cfg_rdata[ANA_LSB +: NCH];
    assign dig_en    = cfg_rdata[DIG_LSB +: NCH];
    assign ctl_div   = cfg_rdata[CDIV_LSB +: CDIV_W];
    assign warm_last = warm_last_of(code);

    adc_ws_prescale #(.DIV_W(CDIV_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (glb_en),
        .div  (ctl_div),
        .tick (ctl_tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        adc_ws_chan #(.DIV_W(CH_DIV_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_tick (ctl_tick),
            .ana_en   (ana_en[i]),
            .dig_en   (dig_en[i]),
            .div      (chan_div[i*CH_DIV_W +: CH_DIV_W]),
            .warm_last(warm_last),
            .rdy_clr  (rdy_clr[i]),
            .ana_rdy  (ana_rdy[i]),
            .dig_rdy  (dig_rdy[i])
        );
    end
endmodule

// File: tb/adc_warmup_seq_tb.sv
module adc_warmup_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_werr;
    logic [15:0] chan_div = '0;
    logic [3:0]  rdy_clr = '0;
    logic [3:0]  ana_rdy;
    logic [3:0]  dig_rdy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    adc_warmup_seq u_dut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_werr(cfg_werr),
        .chan_div(chan_div), .rdy_clr(rdy_clr), .ana_rdy(ana_rdy), .dig_rdy(dig_rdy)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [31:0] mk(input int code, input logic [3:0] ana,
                                       input logic [3:0] dig, input int d);
        return (32'(code) << 24) | (32'(ana) << 20) | (32'(dig) << 16) | (32'(d) << 8);
    endfunction

    function automatic longint warm_len(input int code);
        return (code < 5) ? 16 : (64'd1 << code);
    endfunction

    // configure, run from a clean start and time every channel's flags
    task automatic timed_run(input int code, input int d, input logic [15:0] divs);
        longint per [4];
        longint ea [4];
        longint fa [4];
        longint fd [4];
        longint lim;
        @(negedge clk);
        glb_en = 1'b0;
        chan_div = divs;
        wr_cfg(mk(code, 4'h0, 4'h0, d));
        wr_cfg(mk(code, 4'hF, 4'hF, d));
        lim = 0;
        for (int c = 0; c < 4; c++) begin
            int m = int'(divs[c*4 +: 4]);
            if (m == 0) m = 1;
            per[c] = 2 * m * (d + 1);
            ea[c] = warm_len(code) * per[c];
            if (ea[c] + per[c] > lim) lim = ea[c] + per[c];
            fa[c] = 0;
            fd[c] = 0;
        end
        glb_en = 1'b1;
        for (longint n = 1; n <= lim + 4; n++) begin
            @(posedge clk);
            @(negedge clk);
            for (int c = 0; c < 4; c++) begin
                if (fa[c] == 0 && ana_rdy[c]) fa[c] = n;
                if (fd[c] == 0 && dig_rdy[c]) fd[c] = n;
            end
        end
        glb_en = 1'b0;
        for (int c = 0; c < 4; c++) begin
            chk($sformatf("R4 R5 ana_rdy edge code=%0d D=%0d ch=%0d", code, d, c), fa[c], ea[c]);
            chk($sformatf("R8 dig_rdy edge code=%0d D=%0d ch=%0d", code, d, c), fd[c], ea[c] + per[c]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int first;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rdata", cfg_rdata, 0);
        chk("R1 ana_rdy", ana_rdy, 0);
        chk("R1 dig_rdy", dig_rdy, 0);
        chk("R1 werr", cfg_werr, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after release", cfg_rdata, 0);

        // R3 field mask, R2 unlocked write
        wr_cfg(32'hFFFF_FFFF);
        chk("R3 readback mask", cfg_rdata, 32'h7FFF_3F00);
        chk("R2 no error unlocked", cfg_werr, 0);
        // R2 locked write
        glb_en = 1'b1;
        wr_cfg(32'h0000_0000);
        chk("R2 error pulse", cfg_werr, 1);
        chk("R2 register kept", cfg_rdata, 32'h7FFF_3F00);
        @(negedge clk);
        chk("R2 error one cycle", cfg_werr, 0);
        glb_en = 1'b0;
        wr_cfg(32'h1234_5678);
        chk("R3 readback pattern", cfg_rdata, 32'h1234_1600);

        // R4 R5 R8 timing sweep
        for (int d = 0; d < 3; d++) begin
            for (int code = 0; code < 8; code++) begin
                timed_run(code, d, 16'h3210);
            end
        end
        timed_run(15, 0, 16'h0000);

        // R9 pause mid warm-up (code 0, D 0, M 1: 32 enabled edges)
        chan_div = 16'h0000;
        wr_cfg(mk(0, 4'h0, 4'h0, 0));
        wr_cfg(mk(0, 4'h1, 4'h1, 0));
        glb_en = 1'b1;
        n = 0;
        first = 0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); @(negedge clk); n++;
        end
        glb_en = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); @(negedge clk);
            if (ana_rdy[0]) first = -1;
        end
        chk("R9 no progress while paused", first, 0);
        glb_en = 1'b1;
        while (n < 40) begin
            @(posedge clk); @(negedge clk); n++;
            if (first == 0 && ana_rdy[0]) first = n;
        end
        chk("R9 ready after 32 enabled edges", first, 32);
        chk("R8 dig after pause", dig_rdy[0], 1);

        // R7 write-1-clear, no re-set while warm
        rdy_clr = 4'h1;
        @(negedge clk);
        rdy_clr = 4'h0;
        chk("R7 cleared", ana_rdy[0], 0);
        repeat (100) @(negedge clk);
        chk("R7 stays clear", ana_rdy[0], 0);
        chk("R7 dig unaffected", dig_rdy[0], 1);

        // R6 drop analog enable
        glb_en = 1'b0;
        wr_cfg(mk(0, 4'h0, 4'h1, 0));
        chk("R6 ana_rdy drops", ana_rdy, 0);
        chk("R6 dig_rdy drops", dig_rdy, 0);
        wr_cfg(mk(0, 4'h1, 4'h1, 0));
        glb_en = 1'b1;
        first = 0;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk); @(negedge clk);
            if (first == 0 && ana_rdy[0]) first = k;
        end
        chk("R6 R7 full new warm-up", first, 32);

        // R8 gating by the analog enable
        glb_en = 1'b0;
        wr_cfg(mk(0, 4'h0, 4'h0, 0));
        wr_cfg(mk(0, 4'h5, 4'hF, 0));
        glb_en = 1'b1;
        repeat (100) @(negedge clk);
        chk("R8 dig gated by analog", dig_rdy, 4'h5);
        chk("R8 ana mask", ana_rdy, 4'h5);
        glb_en = 1'b0;
        wr_cfg(mk(0, 4'h0, 4'h0, 0));
        wr_cfg(mk(0, 4'hF, 4'h3, 0));
        glb_en = 1'b1;
        repeat (100) @(negedge clk);
        chk("R8 dig needs digital enable", dig_rdy, 4'h3);
        chk("R4 all warm", ana_rdy, 4'hF);
        glb_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule